// File: doc/BRIEF.md
# Crosspoint Serial Configuration Controller

This block configures a 16-output video routing matrix from 16-bit command words that arrive over a three-wire serial link. The link consists of a serial clock, a serial data line and an active-low framing enable. All three are sampled in the system clock domain. While the framing enable is low, each rising serial clock edge shifts one data bit into a receive register, least significant bit first. When the framing enable returns high, a frame of exactly 16 edges is decoded into a configuration bank. Any other edge count causes the frame to be dropped.

The bank holds the following state:
- a 4-bit source select, an enable bit and a gain bit for each output;
- a global power bit and a global common-enable bit;
- a broadcast mode with its own source select.

Broadcast overrides the effective source of every output. The stored per-output routing is left untouched, so clearing broadcast brings it back. A serial output line returns the previous receive-register contents, most significant bit first, for readback or chaining. The link is a plain serial protocol with no valid/ready stream: it has no back-pressure, and the controller accepts every framed word. The serial clock must stay high and low for at least two system clocks each.

Top module: `xpt_serial_cfg`

## Requirements
- R1: While `ser_frame_n` is low, each rising edge of `ser_clk` shifts `ser_dat` into a 16-bit receive register, and the first bit received becomes bit 0 of the word.
- R2: A word is decoded only after `ser_frame_n` returns high. `ser_clk` edges seen while `ser_frame_n` is high change nothing.
- R3: A frame with fewer or more than 16 rising `ser_clk` edges changes no configuration.
- R4: Opcode bits 15..13 = 111 is a control word. Bit 1 writes the power bit and bit 0 writes the common-enable bit. The word is rejected when any of bits 8..2 is set.
- R5: Opcode 001 writes output enables and opcode 010 writes gain bits. Bits 9..8 give a group N, and bits 6, 4, 2 and 0 carry the values for outputs 4N+3, 4N+2, 4N+1 and 4N.
- R6: Opcode 000 is a routing word. Bits 12..9 give the source and bits 4..1 give the output. The word is ignored if bit 8 or bit 0 is set.
- R7: Opcode 011 is a broadcast word. Bits 12..9 set the broadcast source and bit 0 sets or clears broadcast mode. The word is ignored if bit 8 is set. While broadcast mode is on, every output's effective select equals the broadcast source.
- R8: Broadcast never alters the stored per-output routing. Routing words received during broadcast update the stored routing, and clearing broadcast restores the stored values as the effective selects.
- R9: `out_en[o]` is high only when the power bit, the common-enable bit and output o's enable bit are all set.
- R10: After reset, all enables, gains, selects, the power bit, the common-enable bit and broadcast mode are zero.
- R11: When a frame starts, `ser_out` presents bit 15 of the receive register as it stood then. Each accepted `ser_clk` edge advances `ser_out` to the next lower bit.
- R12: Opcodes 100, 101 and 110 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, sampled by clk |
| ser_dat | input | 1 | Serial data in |
| ser_frame_n | input | 1 | Active-low framing enable |
| ser_out | output | 1 | Serial readback data |
| src_sel | output | NUM_OUT*SEL_W | Effective source select, output o at bits o*SEL_W |
| out_en | output | NUM_OUT | Effective output enable |
| gain_x2 | output | NUM_OUT | Per-output gain bit (1 = double) |

## Verification
The bench builds the block with its default values: 16 outputs, a 4-bit select and a 16-bit word. With these values, all four enable and gain groups and every routing address can be reached. Broadcast is entered and left with routing writes in between, to show the stored routing is kept. Frames of 15 and 17 edges, stray clocks outside a frame, guarded-bit violations and unused opcodes are all driven. The serial readback is checked bit by bit against the previous register contents.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_OUT = 16;
  localparam int SEL_W   = 4;
  localparam int LANES   = 4;

  typedef enum logic [2:0] {
    OP_ROUTE = 3'b000,
    OP_ENA   = 3'b001,
    OP_GAIN  = 3'b010,
    OP_BCAST = 3'b011,
    OP_CTRL  = 3'b111
  } op_e;
endpackage

// File: rtl/xpt_ser_rx.sv
module xpt_ser_rx #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_frame_n,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              sdo
);
  logic              clk_q, clk_d, dat_q, fr_q, fr_d;
  logic [WORD_W-1:0] shreg, tx_q;
  logic [CNT_W-1:0]  cnt;
  logic              rise, fr_start, fr_end;

  assign rise     = clk_q & ~clk_d & ~fr_q;
  assign fr_start = ~fr_q & fr_d;
  assign fr_end   = fr_q & ~fr_d;
  assign sdo      = tx_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0; clk_d <= 1'b0; dat_q <= 1'b0;
      fr_q  <= 1'b1; fr_d  <= 1'b1;
    end else begin
      clk_q <= ser_clk; clk_d <= clk_q; dat_q <= ser_dat;
      fr_q  <= ser_frame_n; fr_d <= fr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      tx_q     <= '0;
      cnt      <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (fr_start) begin
        tx_q <= shreg;
        cnt  <= '0;
      end else if (rise) begin
        shreg <= {dat_q, shreg[WORD_W-1:1]};
        tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
        if (cnt != CNT_W'(WORD_W + 1)) cnt <= cnt + 1'b1;
      end
      if (fr_end) begin
        word_vld <= (cnt == CNT_W'(WORD_W));
        word     <= shreg;
      end
    end
  end

  // R2: receive register holds while framing enable is high
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fr_q |=> $stable(shreg));
  // R3: a decoded word always comes from a full-length frame
  a_r3_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> cnt == CNT_W'(WORD_W));
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W + 1));
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
  import xpt_pkg::*;
#(
  parameter int NUM_OUT = 16,
  parameter int SEL_W   = 4,
  parameter int WORD_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     word_vld,
  input  logic [WORD_W-1:0]        word,
  output logic [NUM_OUT*SEL_W-1:0] route_flat,
  output logic [NUM_OUT-1:0]       ena,
  output logic [NUM_OUT-1:0]       gain,
  output logic                     pwr,
  output logic                     com_en,
  output logic                     bc_on,
  output logic [SEL_W-1:0]         bc_src
);
  logic [SEL_W-1:0] route_q [NUM_OUT];
  logic [2:0]       op;

  assign op = word[15:13];

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_flat
    assign route_flat[o*SEL_W +: SEL_W] = route_q[o];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NUM_OUT; o++) route_q[o] <= '0;
      ena <= '0; gain <= '0; pwr <= 1'b0; com_en <= 1'b0;
      bc_on <= 1'b0; bc_src <= '0;
    end else if (word_vld) begin
      case (op)
        OP_CTRL: if (word[8:2] == '0) begin
          pwr    <= word[1];
          com_en <= word[0];
        end
        OP_ENA:
          for (int o = 0; o < NUM_OUT; o++)
            if (word[9:8] == 2'(o / LANES)) ena[o] <= word[2*(o % LANES)];
        OP_GAIN:
          for (int o = 0; o < NUM_OUT; o++)
            if (word[9:8] == 2'(o / LANES)) gain[o] <= word[2*(o % LANES)];
        OP_ROUTE: if (!word[8] && !word[0]) route_q[word[4:1]] <= word[12:9];
        OP_BCAST: if (!word[8]) begin
          bc_on  <= word[0];
          bc_src <= word[12:9];
        end
        default: ;
      endcase
    end
  end

  // R4: rejected control word leaves global bits alone
  a_r4_ctrl_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && op == OP_CTRL && word[8:2] != '0) |=> ($stable(pwr) && $stable(com_en)));
  // R6: guarded routing bits block the write
  a_r6_route_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && op == OP_ROUTE && (word[8] || word[0])) |=> $stable(route_flat));
  // R8: broadcast words never touch stored routing
  a_r8_keep_routes: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && op == OP_BCAST) |=> $stable(route_flat));
  // R12: unused opcodes change nothing
  a_r12_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && (op == 3'b100 || op == 3'b101 || op == 3'b110)) |=>
      ($stable(route_flat) && $stable(ena) && $stable(gain) && $stable(pwr) &&
       $stable(com_en) && $stable(bc_on) && $stable(bc_src)));
endmodule

// File: rtl/xpt_route_out.sv
module xpt_route_out #(
  parameter int NUM_OUT = 16,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_OUT*SEL_W-1:0] route_flat,
  input  logic [NUM_OUT-1:0]       ena,
  input  logic                     pwr,
  input  logic                     com_en,
  input  logic                     bc_on,
  input  logic [SEL_W-1:0]         bc_src,
  output logic [NUM_OUT*SEL_W-1:0] src_sel,
  output logic [NUM_OUT-1:0]       out_en
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign src_sel[o*SEL_W +: SEL_W] = bc_on ? bc_src : route_flat[o*SEL_W +: SEL_W];
    assign out_en[o] = pwr & com_en & ena[o];
  end
endmodule

// File: rtl/xpt_serial_cfg.sv
module xpt_serial_cfg
  import xpt_pkg::*;
#(
  parameter int NUM_OUT_P = NUM_OUT,
  parameter int SEL_W_P   = SEL_W,
  parameter int WORD_W_P  = WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_clk,
  input  logic                         ser_dat,
  input  logic                         ser_frame_n,
  output logic                         ser_out,
  output logic [NUM_OUT_P*SEL_W_P-1:0] src_sel,
  output logic [NUM_OUT_P-1:0]         out_en,
  output logic [NUM_OUT_P-1:0]         gain_x2
);
  logic                         word_vld;
  logic [WORD_W_P-1:0]          word;
  logic [NUM_OUT_P*SEL_W_P-1:0] route_flat;
  logic [NUM_OUT_P-1:0]         ena;
  logic                         pwr, com_en, bc_on;
  logic [SEL_W_P-1:0]           bc_src;

  xpt_ser_rx #(.WORD_W(WORD_W_P)) u_rx (
    .clk, .rst_n, .ser_clk, .ser_dat, .ser_frame_n,
    .word_vld, .word, .sdo(ser_out)
  );

  xpt_cfg_bank #(.NUM_OUT(NUM_OUT_P), .SEL_W(SEL_W_P), .WORD_W(WORD_W_P)) u_bank (
    .clk, .rst_n, .word_vld, .word, .route_flat, .ena, .gain(gain_x2),
    .pwr, .com_en, .bc_on, .bc_src
  );

  xpt_route_out #(.NUM_OUT(NUM_OUT_P), .SEL_W(SEL_W_P)) u_out (
    .route_flat, .ena, .pwr, .com_en, .bc_on, .bc_src, .src_sel, .out_en
  );

  // R9: no output drives without both global bits
  a_r9_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en != '0) |-> (pwr && com_en));
  // R7: in broadcast, first and last outputs share one source
  a_r7_bcast_same: assert property (@(posedge clk) disable iff (!rst_n)
    bc_on |-> (src_sel[SEL_W_P-1:0] == src_sel[NUM_OUT_P*SEL_W_P-1 -: SEL_W_P]));
endmodule

// File: tb/tb_xpt_serial_cfg.sv
module tb_xpt_serial_cfg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_frame_n = 1'b1;
  logic        ser_out;
  logic [63:0] src_sel;
  logic [15:0] out_en, gain_x2;

  xpt_serial_cfg dut (.clk, .rst_n, .ser_clk, .ser_dat, .ser_frame_n,
                      .ser_out, .src_sel, .out_en, .gain_x2);

  always #2 clk = ~clk;

  int    n_chk = 0, n_bad = 0;
  bit    cmp_en = 1'b0, done = 1'b0;
  string cur_req = "R10";

  // behavioural model
  int          m_route [16];
  bit          m_ena [16], m_gain [16];
  bit          m_pwr = 0, m_com = 0, m_bc = 0;
  int          m_bcsrc = 0;
  logic [15:0] m_sh = '0;

  initial for (int i = 0; i < 16; i++) begin m_route[i] = 0; m_ena[i] = 0; m_gain[i] = 0; end

  task automatic model_apply(logic [15:0] w);
    int op = w[15:13];
    int g  = w[9:8];
    case (op)
      7: if (w[8:2] == 0) begin m_pwr = w[1]; m_com = w[0]; end
      1: for (int k = 0; k < 4; k++) m_ena[4*g+k] = w[2*k];
      2: for (int k = 0; k < 4; k++) m_gain[4*g+k] = w[2*k];
      0: if (!w[8] && !w[0]) m_route[w[4:1]] = w[12:9];
      3: if (!w[8]) begin m_bc = w[0]; m_bcsrc = w[12:9]; end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      logic [63:0] e_sel;
      logic [15:0] e_en, e_gain;
      for (int o = 0; o < 16; o++) begin
        e_sel[o*4 +: 4] = 4'(m_bc ? m_bcsrc : m_route[o]);
        e_en[o]   = m_pwr & m_com & m_ena[o];
        e_gain[o] = m_gain[o];
      end
      n_chk++;
      if (src_sel !== e_sel || out_en !== e_en || gain_x2 !== e_gain) begin
        n_bad++;
        $display("FAIL %s: sel=%h en=%h gain=%h expected sel=%h en=%h gain=%h",
                 cur_req, src_sel, out_en, gain_x2, e_sel, e_en, e_gain);
      end
    end
  end

  task automatic clks(int n); repeat (n) @(negedge clk); endtask

  task automatic send(logic [15:0] w, int nedge, string req);
    logic [15:0] prev = m_sh;
    cur_req = req;
    ser_frame_n = 1'b0; clks(4);
    for (int i = 0; i < nedge; i++) begin
      if (i < 16) begin
        n_chk++;
        if (ser_out !== prev[15-i]) begin
          n_bad++;
          $display("FAIL R11 bit %0d: ser_out=%b expected %b", i, ser_out, prev[15-i]);
        end
      end
      ser_dat = (i < 16) ? w[i] : 1'b0;
      clks(4); ser_clk = 1'b1; clks(4); ser_clk = 1'b0;
      m_sh = {ser_dat, m_sh[15:1]};   // R1: first bit ends in bit 0
    end
    clks(2); cmp_en = 1'b0; ser_frame_n = 1'b1;
    if (nedge == 16) model_apply(w);
    clks(8); cmp_en = 1'b1;
  endtask

  task automatic stray_clocks(int n);
    cur_req = "R2";
    for (int i = 0; i < n; i++) begin
      ser_dat = i[0]; clks(3); ser_clk = 1'b1; clks(3); ser_clk = 1'b0;
    end
    clks(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clks(3); rst_n = 1'b1; clks(2); cmp_en = 1'b1;
    cur_req = "R10"; clks(10);
    // R5: enables and gains, all groups, mixed patterns
    for (int g = 0; g < 4; g++) send(16'h2000 | 16'(g << 8) | 16'h0055, 16, "R5");
    send(16'h2000 | 16'h0100 | 16'h0011, 16, "R5");
    for (int g = 0; g < 4; g++) send(16'h4000 | 16'(g << 8) | 16'((g * 5) & 16'h55), 16, "R5");
    // R9 with globals off, then R4
    send(16'hE002, 16, "R9");
    send(16'hE001, 16, "R9");
    send(16'hE003, 16, "R4");
    send(16'hE004, 16, "R4");
    send(16'hE100, 16, "R4");
    // R6: route all outputs, then guarded violations
    for (int o = 0; o < 16; o++) send(16'((15 - o) << 9) | 16'(o << 1), 16, "R6");
    send(16'(7 << 9) | 16'(3 << 1) | 16'h0001, 16, "R6");
    send(16'(7 << 9) | 16'(3 << 1) | 16'h0100, 16, "R6");
    // R7 / R8: broadcast, routing update during broadcast, restore
    send(16'h6000 | 16'(5 << 9) | 16'h0001, 16, "R7");
    send(16'h6000 | 16'(9 << 9) | 16'h0101, 16, "R7");
    send(16'(2 << 9) | 16'(6 << 1), 16, "R8");
    send(16'h6000 | 16'(12 << 9) | 16'h0001, 16, "R7");
    send(16'h6000, 16, "R8");
    // R3: short and long frames
    send(16'hE000, 15, "R3");
    send(16'hE000, 17, "R3");
    send(16'h2000 | 16'h0300, 12, "R3");
    // R2: stray clocks outside a frame, then readback proves no shift
    stray_clocks(5);
    send(16'h4000 | 16'h0355, 16, "R2");
    // R12: unused opcodes
    send(16'h8000 | 16'h0003, 16, "R12");
    send(16'hA000 | 16'h00FF, 16, "R12");
    send(16'hC000 | 16'h0155, 16, "R12");
    // R1 / R11: distinctive words read back
    send(16'hA5C3, 16, "R1");
    send(16'h0000 | 16'(1 << 9) | 16'(15 << 1), 16, "R1");
    send(16'hE000, 16, "R11");
    clks(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule